// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block generates the address sequence for a four-beat burst on a synchronous burst memory. At the start of a burst, either of two active-low address strobes captures an external start address. The strobe only counts while the load-enable input is high. After that, each clock edge that sees the active-low advance input low steps the two low address bits to the next beat. An edge that sees advance high suspends the burst, and the address holds.

The upper address bits always come from the captured start address. A burst wraps inside its four-word group and never carries into those bits. A static order-select input picks one of two beat orders:
- Interleaved: each beat is the start offset XOR the beat index.
- Linear: the offset counts up by one, modulo 4, from any start offset.

The order is latched at the first clock edge after reset. After that it is fixed until the next reset.

The outputs are the registered full address and a 2-bit beat index, which is 0 for the start address.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and beat_o is 0.
- R2: At a clock edge where load_en_i is high and strobe_a_ni or strobe_b_ni is low, addr_o takes addr_i and beat_o becomes 0. This happens whatever the value of adv_ni.
- R3: A strobe sampled low while load_en_i is low loads nothing. That edge behaves as if both strobes were high.
- R4: At an edge with adv_ni low and no load, beat_o increases by 1 modulo 4.
- R5: At an edge with adv_ni high and no load, addr_o and beat_o keep their values (suspend).
- R6: Bits ADDR_W-1 down to 2 of addr_o change only on a load.
- R7: With order_sel_i = 1 (interleaved), addr_o[1:0] equals start[1:0] XOR beat_o.
- R8: With order_sel_i = 0 (linear), addr_o[1:0] equals (start[1:0] + beat_o) modulo 4. Each advance adds 1 modulo 4.
- R9: An advance from beat 3 returns to beat 0 and to the start offset of the same burst.
- R10: order_sel_i is sampled at the first clock edge after rst_ni rises. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Qualifies the address strobes (device selected) |
| strobe_a_ni | input | 1 | First address strobe, active low |
| strobe_b_ni | input | 1 | Second address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Registered burst address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
The assertions assume that order_sel_i is constant for the whole time the order check is armed. They also assume that strobes and advance are plain synchronous levels with no meaning between clock edges. The bench meets both assumptions:
- It sets order_sel_i before releasing reset.
- It changes order_sel_i only in the test that confirms the change is ignored. At that point the latched order is already fixed, and the assertions check the latched value, not the pin.
- It drives every input on the falling edge.

For each order, the sweep covers every start offset, both strobes, and a load issued together with advance. Each burst runs past the wrap point and includes a suspend in the middle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_mode_latch.sv
module burst_mode_latch
  import burst_addr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   order_sel_i,
  output order_e order_o
);
  logic   armed_q;
  order_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= ORD_INTERLEAVE;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_q  <= order_e'(order_sel_i);
    end
  end

  // before arming the pin is used directly (first cycle only)
  assign order_o = armed_q ? mode_q : order_e'(order_sel_i);

  assert_mode_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> order_o == $past(order_o));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [BEAT_W-1:0] beat_nxt_o
);
  logic [BEAT_W-1:0] beat_q;

  assign beat_nxt_o = beat_q + BEAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (adv_i)  beat_q <= beat_nxt_o;
  end

  assign beat_o = beat_q;

  assert_beat_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> beat_o == BEAT_W'($past(beat_o) + BEAT_W'(1)));
  assert_beat_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
endmodule

// File: rtl/burst_low_seq.sv
module burst_low_seq
  import burst_addr_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] cur_i,
  input  logic [BEAT_W-1:0] beat_nxt_i,
  output logic [BEAT_W-1:0] low_nxt_o
);
  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_nxt_o = start_i ^ beat_nxt_i;
      default:        low_nxt_o = cur_i + BEAT_W'(1);
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              strobe_a_ni,
  input  logic              strobe_b_ni,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic              load, adv;
  order_e            order;
  logic [BEAT_W-1:0] start_q, beat_nxt, low_nxt;
  logic [ADDR_W-1:0] addr_q;

  assign load = load_en_i && (!strobe_a_ni || !strobe_b_ni);
  assign adv  = !adv_ni && !load;

  burst_mode_latch u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .order_sel_i (order_sel_i),
    .order_o     (order)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .adv_i      (adv),
    .beat_o     (beat_o),
    .beat_nxt_o (beat_nxt)
  );

  burst_low_seq #(.BEAT_W(BEAT_W)) u_seq (
    .order_i    (order),
    .start_i    (start_q),
    .cur_i      (addr_q[BEAT_W-1:0]),
    .beat_nxt_i (beat_nxt),
    .low_nxt_o  (low_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
    end else if (load) begin
      addr_q  <= addr_i;
      start_q <= addr_i[BEAT_W-1:0];
    end else if (adv) begin
      addr_q  <= {addr_q[ADDR_W-1:BEAT_W], low_nxt};
    end
  end

  assign addr_o = addr_q;

  assert_load_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> addr_o == $past(addr_i));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_ni) |=> $stable(addr_o) && $stable(beat_o));
  assert_upper_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  assert_interleave_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && order == ORD_INTERLEAVE)
      |=> (addr_o[BEAT_W-1:0] ^ beat_o) == $past(addr_o[BEAT_W-1:0] ^ beat_o));
  assert_linear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && order == ORD_LINEAR)
      |=> addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + BEAT_W'(1)));
  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && beat_o == '1) |=> addr_o[BEAT_W-1:0] == start_q && beat_o == '0);

  initial assert (UP_W >= 1) else $error("ADDR_W too small");
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_en = 1'b0, sa_n = 1'b1, sb_n = 1'b1, adv_n = 1'b1, ord = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .load_en_i(load_en), .strobe_a_ni(sa_n),
    .strobe_b_ni(sb_n), .adv_ni(adv_n), .order_sel_i(ord), .addr_i(addr_in),
    .addr_o(addr_out), .beat_o(beat_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit en, bit a_n, bit b_n, bit v_n, logic [AW-1:0] a);
    @(negedge clk);
    load_en = en; sa_n = a_n; sb_n = b_n; adv_n = v_n; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit m);
    @(negedge clk);
    rst_ni = 1'b0; ord = m; load_en = 1'b0; sa_n = 1'b1; sb_n = 1'b1; adv_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 addr", 32'(addr_out), 32'h0);
    chk("R1 beat", 32'(beat_out), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(0, 1, 1, 1, '0);  // arms the order latch
  endtask

  function automatic logic [1:0] exp_low(bit m, logic [1:0] st, int k);
    return m ? (st ^ 2'(k)) : 2'(st + 2'(k));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(bit'(m));
      for (int st = 0; st < 4; st++) begin
        for (int p = 0; p < 2; p++) begin
          logic [AW-3:0] up;
          logic [AW-1:0] base;
          up   = (AW-2)'(37 * (st + 1) + 1000 * m + 500 * p + 3);
          base = {up, 2'(st)};
          // load together with advance low: load wins (R2)
          cyc(1, p == 0 ? 1'b0 : 1'b1, p == 1 ? 1'b0 : 1'b1, 0, base);
          chk("R2 load addr", 32'(addr_out), 32'(base));
          chk("R2 load beat", 32'(beat_out), 32'h0);
          for (int k = 1; k <= 6; k++) begin
            if (k == 3) begin
              cyc(0, 1, 1, 1, ~base);
              chk("R5 suspend addr", 32'(addr_out), 32'({up, exp_low(bit'(m), 2'(st), 2)}));
              chk("R5 suspend beat", 32'(beat_out), 32'h2);
            end
            cyc(0, 1, 1, 0, ~base);
            chk(m ? "R7 interleave low" : "R8 linear low",
                32'(addr_out[1:0]), 32'(exp_low(bit'(m), 2'(st), k)));
            chk("R4 beat", 32'(beat_out), 32'(k % 4));
            chk("R6 upper", 32'(addr_out[AW-1:2]), 32'(up));
            if (k == 4) chk("R9 wrap", 32'(addr_out[1:0]), 32'(st));
          end
          // strobe without load enable is ignored (R3)
          cyc(0, 0, 0, 1, 16'h1234);
          chk("R3 ignored addr", 32'(addr_out), 32'({up, exp_low(bit'(m), 2'(st), 6)}));
          chk("R3 ignored beat", 32'(beat_out), 32'h2);
        end
      end
    end
    // order pin change after arming has no effect (R10)
    do_reset(1'b1);
    @(negedge clk); ord = 1'b0;
    cyc(1, 0, 1, 1, 16'hBEE1);
    cyc(0, 1, 1, 0, '0);
    chk("R10 frozen order", 32'(addr_out), 32'h0000BEE0);
    cyc(0, 1, 1, 0, '0);
    chk("R10 frozen order", 32'(addr_out), 32'h0000BEE3);
    do_reset(1'b0);
    cyc(1, 1, 0, 1, 16'h0041);
    cyc(0, 1, 1, 0, '0);
    chk("R10 new order after reset", 32'(addr_out), 32'h00000042);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule